// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the software-visible side of a serial port, with no bit-level engine. A processor reaches it through a simple word-addressed bus. A write to the data word hands one byte to the transmitter over a byte-valid strobe. Bytes coming back from the receiver arrive on a byte-valid input with a ready handshake. They are queued in a circular buffer that holds 16 entries when queueing is enabled in the line-control word. With queueing disabled, the buffer acts as a single holding slot.

The block also stores the divisor, line-control, control, level-select, low-power and DMA-control words as plain read/write storage. It reports status flags and a small interrupt set with raw, mask, masked and clear views, and it exposes eight read-only identification bytes. One combined interrupt line goes high whenever an unmasked raw interrupt is pending.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the flag word (word 6) reads 0x90, control (word 12) reads 0x300, level select (word 13) reads 0x12, raw status (word 15) reads 0, `irq` is low and `rx_ready` is high.
- R2: Words 8, 9, 10, 11, 12, 13, 14 and 18 each read back the last value written to them.
- R3: Word addresses 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R4: The receive capacity is 16 bytes when line-control (word 11) bit 4 is set, and 1 byte when that bit is clear. `rx_ready` is low while the held count equals the capacity, and a byte offered while `rx_ready` is low is discarded.
- R5: A read of word 0 returns the oldest held byte in the low 8 bits and removes it, so bytes leave in arrival order.
- R6: A read of word 0 while nothing is held returns the byte stored at the current read position and leaves the queue unchanged.
- R7: Flag bit 4 (receive empty) is 1 exactly when no byte is held. Bit 7 (transmit empty) always reads 1 and bit 5 (transmit full) always reads 0.
- R8: Flag bit 6 (receive full) sets when a stored byte brings the count to 16, or when a byte is stored while control bit 4 is set. Any read of word 0 clears it.
- R9: Raw status bit 4 (receive) sets when a stored byte brings the count to 1. It clears when a word-0 read leaves the count at 0.
- R10: A write to word 0 puts `wdata[7:0]` on `tx_data` with `tx_valid` high in the same cycle, and sets raw status bit 5 (transmit).
- R11: A write to word 17 clears each raw status bit whose `wdata` bit is 1 and leaves the other raw bits unchanged.
- R12: Word 16 reads raw status ANDed with the mask (word 14), and `irq` is high exactly when that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Word address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; used only for read side effects |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | `tx_data` is valid this cycle |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` is offered |
| rx_ready | output | 1 | A byte can be accepted this cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that the held count stays within the buffer size, that a full buffer refuses new bytes, and that an empty data read moves nothing. They also check that a data read clears the receive-full flag and that stored bytes and data writes raise their raw interrupt bits on the next cycle. Arrival order, stale readback, the switch between one-slot and sixteen-slot operation, the identification bytes and selective interrupt clearing can only be shown by the bench's scenarios.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  localparam logic [ADDR_W-1:0] W_DATA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] W_FLAG  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] W_LPWR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] W_IDIV  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] W_FDIV  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] W_LINE  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] W_CTRL  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] W_LVL   = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] W_MASK  = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] W_RAW   = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] W_MSK   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] W_CLR   = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] W_DMA   = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] W_IDLO  = ADDR_W'(10'h3F8);

  logic [DATA_W-1:0] lpwr_q, idiv_q, fdiv_q, line_q, ctrl_q, lvl_q, mask_q, dma_q;
  logic [BYTE_W-1:0] buf_q [DEPTH];
  logic [PTR_W-1:0]  rptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, cap;
  logic              rxff_q, rxint_q, txint_q;
  logic [DATA_W-1:0] raw, flags;

  wire data_wr = wr_en && (addr == W_DATA);
  wire clr_wr  = wr_en && (addr == W_CLR);
  wire pop_req = rd_en && (addr == W_DATA);
  wire pop     = pop_req && (cnt_q != '0);
  wire push    = rx_valid && rx_ready;
  wire [PTR_W-1:0] wslot = rptr_q + cnt_q[PTR_W-1:0];

  assign cap      = line_q[4] ? FULL_C : ONE_C;
  assign rx_ready = cnt_q < cap;
  assign cnt_nx   = cnt_q + CNT_W'(push) - CNT_W'(pop);
  assign tx_valid = data_wr;
  assign tx_data  = wdata[BYTE_W-1:0];

  always_comb begin
    raw = '0;
    raw[4] = rxint_q;
    raw[5] = txint_q;
    flags = '0;
    flags[7] = 1'b1;
    flags[6] = rxff_q;
    flags[4] = (cnt_q == '0);
  end
  assign irq = |(raw & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lpwr_q <= '0; idiv_q <= '0; fdiv_q <= '0; line_q <= '0;
      ctrl_q <= DATA_W'(32'h300); lvl_q <= DATA_W'(32'h12);
      mask_q <= '0; dma_q <= '0;
    end else if (wr_en) begin
      case (addr)
        W_LPWR: lpwr_q <= wdata;
        W_IDIV: idiv_q <= wdata;
        W_FDIV: fdiv_q <= wdata;
        W_LINE: line_q <= wdata;
        W_CTRL: ctrl_q <= wdata;
        W_LVL:  lvl_q  <= wdata;
        W_MASK: mask_q <= wdata;
        W_DMA:  dma_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) buf_q[wslot] <= rx_data;
      if (pop) rptr_q <= rptr_q + PTR_W'(1);
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxff_q <= 1'b0; rxint_q <= 1'b0; txint_q <= 1'b0;
    end else begin
      if (push && (ctrl_q[4] || cnt_nx == FULL_C)) rxff_q <= 1'b1;
      else if (pop_req) rxff_q <= 1'b0;

      if (push && cnt_nx == ONE_C) rxint_q <= 1'b1;
      else if (clr_wr && wdata[4]) rxint_q <= 1'b0;
      else if (pop_req && cnt_nx == '0) rxint_q <= 1'b0;

      if (data_wr) txint_q <= 1'b1;
      else if (clr_wr && wdata[5]) txint_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr >= W_IDLO) begin
      case (addr[2:0])
        3'd0: rdata = DATA_W'(8'h11);
        3'd1: rdata = DATA_W'(8'h10);
        3'd2: rdata = DATA_W'(8'h14);
        3'd3: rdata = DATA_W'(8'h00);
        3'd4: rdata = DATA_W'(8'h0D);
        3'd5: rdata = DATA_W'(8'hF0);
        3'd6: rdata = DATA_W'(8'h05);
        default: rdata = DATA_W'(8'hB1);
      endcase
    end else begin
      case (addr)
        W_DATA: rdata = DATA_W'(buf_q[rptr_q]);
        W_FLAG: rdata = flags;
        W_LPWR: rdata = lpwr_q;
        W_IDIV: rdata = idiv_q;
        W_FDIV: rdata = fdiv_q;
        W_LINE: rdata = line_q;
        W_CTRL: rdata = ctrl_q;
        W_LVL:  rdata = lvl_q;
        W_MASK: rdata = mask_q;
        W_RAW:  rdata = raw;
        W_MSK:  rdata = raw & mask_q;
        W_DMA:  rdata = dma_q;
        default: rdata = '0;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= FULL_C); // R4
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n) (cnt_q == FULL_C) |-> !rx_ready); // R4
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !rx_valid) |=> ($stable(rptr_q) && cnt_q == '0)); // R6
  AST_FULL_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (pop_req && !rx_valid) |=> !rxff_q); // R8
  AST_RX_INT_RISES: assert property (@(posedge clk) disable iff (!rst_n) (push && cnt_q == '0 && !rd_en) |=> rxint_q); // R9
  AST_TX_INT_RISES: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |=> txint_q); // R10
endmodule

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  uart_regfile u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {word address, value written, value expected on readback}  (R2)
  localparam logic [73:0] VEC [9] = '{
    {10'd8,  32'h0000005A, 32'h0000005A},
    {10'd9,  32'h00001234, 32'h00001234},
    {10'd10, 32'h0000003F, 32'h0000003F},
    {10'd13, 32'h00000024, 32'h00000024},
    {10'd18, 32'h00000003, 32'h00000003},
    {10'd14, 32'h00000000, 32'h00000000},
    {10'd12, 32'h00000301, 32'h00000301},
    {10'd12, 32'h00000300, 32'h00000300},
    {10'd11, 32'h00000060, 32'h00000060}
  };
  localparam logic [7:0] IDB [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(logic [9:0] a, output logic [31:0] v);
    addr = a; #1 v = rdata;
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] b, output logic took);
    rx_data = b; rx_valid = 1'b1; #1 took = rx_ready;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic took;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(10'd6, v);  chk("R1 flags", v, 32'h90);
    peek(10'd12, v); chk("R1 control", v, 32'h300);
    peek(10'd13, v); chk("R1 level", v, 32'h12);
    peek(10'd15, v); chk("R1 raw", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      peek(VEC[i][73:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end
    wr(10'd11, 32'h0);

    for (int k = 0; k < 8; k++) begin
      peek(10'h3F8 + 10'(k), v);
      chk("R3 id byte", v, {24'b0, IDB[k]});
    end

    // single-slot mode
    push(8'hA1, took); chk("R4 accept one", {31'b0, took}, 32'h1);
    chk("R4 ready low", {31'b0, rx_ready}, 32'h0);
    push(8'hA2, took); chk("R4 refuse second", {31'b0, took}, 32'h0);
    peek(10'd15, v); chk("R9 rx int set", v, 32'h10);
    peek(10'd6, v);  chk("R7 not empty", v, 32'h80);
    rd(10'd0, v);    chk("R5 data", v, 32'hA1);
    peek(10'd6, v);  chk("R7 empty again", v, 32'h90);
    peek(10'd15, v); chk("R9 rx int clear", v, 32'h0);

    // sixteen-slot mode
    wr(10'd11, 32'h10);
    for (int i = 0; i < 16; i++) begin
      push(8'h30 + 8'(i), took);
      chk("R4 accept fifo", {31'b0, took}, 32'h1);
    end
    chk("R4 ready low full", {31'b0, rx_ready}, 32'h0);
    peek(10'd6, v); chk("R8 full flag", v, 32'hC0);
    push(8'hEE, took); chk("R4 refuse full", {31'b0, took}, 32'h0);
    rd(10'd0, v); chk("R5 first", v, 32'h30);
    peek(10'd6, v); chk("R8 full cleared", v, 32'h80);
    for (int i = 1; i < 16; i++) begin
      rd(10'd0, v); chk("R5 order", v, 32'h30 + 32'(i));
    end
    peek(10'd6, v); chk("R7 drained", v, 32'h90);
    rd(10'd0, v); chk("R6 stale byte", v, 32'h30);
    peek(10'd6, v); chk("R6 still empty", v, 32'h90);
    chk("R6 ready", {31'b0, rx_ready}, 32'h1);
    push(8'h77, took);
    rd(10'd0, v); chk("R6 pointer kept", v, 32'h77);

    // receive-full forced by control bit 4
    wr(10'd12, 32'h310);
    push(8'h5C, took);
    peek(10'd6, v); chk("R8 forced full", v, 32'hC0);
    rd(10'd0, v); chk("R5 forced data", v, 32'h5C);
    peek(10'd6, v); chk("R8 cleared by read", v, 32'h90);
    wr(10'd12, 32'h300);

    // transmit and interrupts
    addr = 10'd0; wdata = 32'h142; wr_en = 1'b1; #1;
    chk("R10 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R10 tx_data", {24'b0, tx_data}, 32'h42);
    @(negedge clk); wr_en = 1'b0;
    peek(10'd15, v); chk("R10 tx int", v, 32'h20);
    chk("R12 masked off", {31'b0, irq}, 32'h0);
    wr(10'd14, 32'h20);
    chk("R12 irq on", {31'b0, irq}, 32'h1);
    peek(10'd16, v); chk("R12 masked status", v, 32'h20);
    push(8'h99, took);
    peek(10'd15, v); chk("R11 both raw", v, 32'h30);
    wr(10'd17, 32'h20);
    peek(10'd15, v); chk("R11 only tx cleared", v, 32'h10);
    chk("R12 irq off", {31'b0, irq}, 32'h0);
    wr(10'd14, 32'h10);
    chk("R12 rx irq", {31'b0, irq}, 32'h1);
    wr(10'd17, 32'h10);
    peek(10'd15, v); chk("R11 rx cleared", v, 32'h0);
    peek(10'd6, v); chk("R11 byte kept", v, 32'h80);
    rd(10'd0, v); chk("R5 last", v, 32'h99);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule